// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block lives inside a synchronous DRAM controller and is the only source of refresh-related commands on the memory command bus. A free-running interval timer, sized from the clock frequency when the design is elaborated, marks each refresh period. Each period becomes a pending refresh job. When a job is pending, the block asks the main access engine for the bus with `refreshReq`. Once `refreshGnt` comes back, it closes every bank with a precharge-all command and waits out the precharge time. It then issues one auto-refresh, or a whole burst of them in burst mode, and spaces each one by the row-cycle time. Finally it returns the bus with a one-cycle `refreshDone` pulse.

Jobs that cannot be served because the bus stays busy are counted, up to eight. One more interval beyond that sets a sticky error flag. The same handshake also carries self-refresh. When `srEnter` is granted, the block closes all banks and drops CKE together with the refresh encoding. It holds CKE low until `srExit` is honoured. It then raises CKE and drives NOPs for a full row-cycle time. In burst mode it follows this with a recovery burst of refreshes before it gives the bus back. Timing values are given in nanoseconds and rounded up to whole clocks.

Top module: `refresh_seq`

## Requirements
- R1: The first command after a granted job is precharge-all: CS, RAS and WE low, CAS high, with `memA10` high.
- R2: The first auto-refresh of a refresh job comes exactly T_RP_CYC cycles after the precharge-all, where T_RP_CYC = ceil(T_RP_NS*CLK_MHZ/1000), and only NOPs are driven in between.
- R3: Auto-refresh is CS, RAS and CAS low, WE high, with CKE high in this cycle and the one before. Consecutive auto-refreshes are T_RC_CYC = ceil(T_RC_NS*CLK_MHZ/1000) cycles apart, with only NOPs between them.
- R4: A refresh job issues BURST_LEN auto-refreshes when BURST_MODE=1 and one otherwise. `refreshDone` is high for exactly one cycle, T_RC_CYC cycles after the last auto-refresh.
- R5: `refreshReq` is high only while the block is idle and a job is pending or `srEnter` is high. No command leaves the block before a grant. The first interval becomes pending after REF_INTERVAL_NS*CLK_MHZ/1000 clocks from reset release.
- R6: Intervals that elapse while the grant is withheld are kept, and each one is later served by its own complete job.
- R7: An interval that elapses while eight jobs are already pending sets `pendErr`. The flag stays high until reset.
- R8: A granted `srEnter` produces precharge-all, then T_RP_CYC cycles later the auto-refresh encoding with `memCke` low in that same cycle. CKE stays low, with only NOPs driven, until exit.
- R9: `srExit` has no effect while idle. It is also ignored in the entry cycle and in the first cycle of self-refresh, and it is honoured from the second self-refresh cycle on.
- R10: On exit, CKE rises and NOPs are driven for T_RC_CYC cycles. With BURST_MODE=1, a burst of BURST_LEN auto-refreshes spaced T_RC_CYC apart follows, and then `refreshDone`.
- R11: `seqStatus` reads 0 when idle, 1 during precharge, refresh and done cycles, 2 in the self-refresh entry cycle and during self-refresh, and 3 during the exit NOP window.
- R12: During reset the block drives CKE high, a NOP, status 0, and `refreshReq`, `refreshDone` and `pendErr` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Synchronous active-low reset |
| refreshReq | output | 1 | Asks the access engine for the command bus |
| refreshGnt | input | 1 | Bus handed over; sampled only while idle |
| refreshDone | output | 1 | One-cycle pulse that returns the bus |
| srEnter | input | 1 | Request to enter self-refresh (level) |
| srExit | input | 1 | Request to leave self-refresh (level) |
| memCke | output | 1 | Clock enable to the memory |
| memCsN | output | 1 | Chip select, active low |
| memRasN | output | 1 | Row strobe, active low |
| memCasN | output | 1 | Column strobe, active low |
| memWeN | output | 1 | Write enable, active low |
| memA10 | output | 1 | Address bit 10; high selects all banks on precharge |
| seqStatus | output | 2 | 0 idle, 1 refreshing, 2 self-refresh, 3 exiting |
| pendErr | output | 1 | Sticky overflow of postponed refresh jobs |

## Verification
A wrong wait counter shows up as an auto-refresh, or a CKE rise, landing a cycle early or late against the command before it. The scoreboard stamps every command with its gap from the previous one, so the error is caught at that first misplaced command. A wrong refresh count shows up at the done pulse, as one refresh too many or too few inside the job. A lost or extra pending count only becomes visible later, as a missing job, a missing request, or an error flag that is wrong once the grant is withheld. The bench checks for this after several intervals have been postponed.

// File: rtl/refresh_seq_pkg.sv
package refresh_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE, ST_TRP, ST_REF, ST_TRC, ST_SRE, ST_SELF, ST_SXIT, ST_DONE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadRp;
    logic loadRc;
    logic loadExit;
    logic decWait;
    logic loadJob;
    logic loadBurst;
    logic decRef;
    logic popPend;
    logic clrLowSeen;
    logic inSelf;
  } seqStrobe_t;

  // conditions reported back from the datapath
  typedef struct packed {
    logic waitZero;
    logic refZero;
    logic pendAny;
    logic lowSeen;
  } seqFlags_t;

endpackage

// File: rtl/refresh_seq_dpath.sv
module refresh_seq_dpath
  import refresh_seq_pkg::*;
#(
  parameter int T_RP_CYC     = 2,
  parameter int T_RC_CYC     = 6,
  parameter int INTERVAL_CYC = 1560,
  parameter int JOB_LEN      = 1,
  parameter int BURST_LEN    = 4096,
  parameter int PEND_MAX     = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  output seqFlags_t  flags,
  output logic       pendErr
);

  localparam int WAIT_MAX = (T_RP_CYC > T_RC_CYC) ? T_RP_CYC : T_RC_CYC;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam int REF_MAX  = (JOB_LEN > BURST_LEN) ? JOB_LEN : BURST_LEN;
  localparam int REF_W    = $clog2(REF_MAX + 1);
  localparam int IV_W     = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;
  localparam int PEND_W   = $clog2(PEND_MAX + 1);

  logic [WAIT_W-1:0] waitCnt;
  logic [REF_W-1:0]  refCnt;
  logic [IV_W-1:0]   intervalCnt;
  logic [PEND_W-1:0] pendCnt;
  logic              lowSeen;
  logic              tick;

  // wait counter shared by tRP, tRC and the exit window
  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (strobe.loadRp) begin
      waitCnt <= WAIT_W'(T_RP_CYC - 2);
    end else if (strobe.loadRc) begin
      waitCnt <= WAIT_W'(T_RC_CYC - 2);
    end else if (strobe.loadExit) begin
      waitCnt <= WAIT_W'(T_RC_CYC - 1);
    end else if (strobe.decWait && (waitCnt != '0)) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

  // refreshes still to issue in the current job
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refCnt <= '0;
    end else if (strobe.loadJob) begin
      refCnt <= REF_W'(JOB_LEN);
    end else if (strobe.loadBurst) begin
      refCnt <= REF_W'(BURST_LEN);
    end else if (strobe.decRef && (refCnt != '0)) begin
      refCnt <= refCnt - 1'b1;
    end
  end

  // interval timer, frozen while the memory refreshes itself
  assign tick = !strobe.inSelf && (intervalCnt == IV_W'(INTERVAL_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intervalCnt <= '0;
    end else if (tick) begin
      intervalCnt <= '0;
    end else if (!strobe.inSelf) begin
      intervalCnt <= intervalCnt + 1'b1;
    end
  end

  // postponed intervals and overflow flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendCnt <= '0;
      pendErr <= 1'b0;
    end else begin
      unique case ({tick, strobe.popPend})
        2'b10: begin
          if (pendCnt == PEND_W'(PEND_MAX)) pendErr <= 1'b1;
          else                              pendCnt <= pendCnt + 1'b1;
        end
        2'b01: begin
          if (pendCnt != '0) pendCnt <= pendCnt - 1'b1;
        end
        default: ;
      endcase
    end
  end

  // set once a full self-refresh cycle has passed with CKE low
  always_ff @(posedge clk) begin
    if (!rstN)                  lowSeen <= 1'b0;
    else if (strobe.clrLowSeen) lowSeen <= 1'b0;
    else if (strobe.inSelf)     lowSeen <= 1'b1;
  end

  assign flags.waitZero = (waitCnt == '0);
  assign flags.refZero  = (refCnt == '0);
  assign flags.pendAny  = (pendCnt != '0);
  assign flags.lowSeen  = lowSeen;

endmodule

// File: rtl/refresh_seq_ctrl.sv
module refresh_seq_ctrl
  import refresh_seq_pkg::*;
#(
  parameter bit RECOVER_BURST = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refreshGnt,
  input  logic       srEnter,
  input  logic       srExit,
  input  seqFlags_t  flags,
  output seqStrobe_t strobe,
  output logic       refreshReq,
  output logic       refreshDone,
  output logic       memCke,
  output logic       memCsN,
  output logic       memRasN,
  output logic       memCasN,
  output logic       memWeN,
  output logic       memA10,
  output logic [1:0] seqStatus
);

  seqState_t state, stateNext;
  logic      srJob, srJobNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      srJob <= 1'b0;
    end else begin
      state <= stateNext;
      srJob <= srJobNext;
    end
  end

  always_comb begin
    stateNext = state;
    srJobNext = srJob;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (refreshGnt && srEnter) begin
          srJobNext = 1'b1;
          stateNext = ST_PRE;
        end else if (refreshGnt && flags.pendAny) begin
          srJobNext      = 1'b0;
          strobe.loadJob = 1'b1;
          stateNext      = ST_PRE;
        end
      end
      ST_PRE: begin
        strobe.loadRp = 1'b1;
        stateNext     = ST_TRP;
      end
      ST_TRP: begin
        if (flags.waitZero) stateNext = srJob ? ST_SRE : ST_REF;
        else                strobe.decWait = 1'b1;
      end
      ST_REF: begin
        strobe.decRef = 1'b1;
        strobe.loadRc = 1'b1;
        stateNext     = ST_TRC;
      end
      ST_TRC: begin
        if (flags.waitZero) stateNext = flags.refZero ? ST_DONE : ST_REF;
        else                strobe.decWait = 1'b1;
      end
      ST_SRE: begin
        strobe.clrLowSeen = 1'b1;
        stateNext         = ST_SELF;
      end
      ST_SELF: begin
        strobe.inSelf = 1'b1;
        if (srExit && flags.lowSeen) begin
          strobe.loadExit = 1'b1;
          stateNext       = ST_SXIT;
        end
      end
      ST_SXIT: begin
        if (flags.waitZero) begin
          if (RECOVER_BURST) begin
            strobe.loadBurst = 1'b1;
            stateNext        = ST_REF;
          end else begin
            stateNext = ST_DONE;
          end
        end else begin
          strobe.decWait = 1'b1;
        end
      end
      ST_DONE: begin
        strobe.popPend = !srJob;
        stateNext      = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // command pins decoded from the current state
  always_comb begin
    memCke  = 1'b1;
    memCsN  = 1'b0;
    memRasN = 1'b1;
    memCasN = 1'b1;
    memWeN  = 1'b1;
    memA10  = 1'b0;
    unique case (state)
      ST_PRE: begin
        memRasN = 1'b0;
        memWeN  = 1'b0;
        memA10  = 1'b1;
      end
      ST_REF: begin
        memRasN = 1'b0;
        memCasN = 1'b0;
      end
      ST_SRE: begin
        memRasN = 1'b0;
        memCasN = 1'b0;
        memCke  = 1'b0;
      end
      ST_SELF: memCke = 1'b0;
      default: ;
    endcase
  end

  always_comb begin
    unique case (state)
      ST_IDLE:         seqStatus = 2'd0;
      ST_SRE, ST_SELF: seqStatus = 2'd2;
      ST_SXIT:         seqStatus = 2'd3;
      default:         seqStatus = 2'd1;
    endcase
  end

  assign refreshReq  = (state == ST_IDLE) && (srEnter || flags.pendAny);
  assign refreshDone = (state == ST_DONE);

endmodule

// File: rtl/refresh_seq.sv
module refresh_seq
  import refresh_seq_pkg::*;
#(
  parameter int CLK_MHZ         = 100,
  parameter int T_RP_NS         = 18,
  parameter int T_RC_NS         = 60,
  parameter int REF_INTERVAL_NS = 15600,
  parameter bit BURST_MODE      = 1'b0,
  parameter int BURST_LEN       = 4096,
  parameter int PEND_MAX        = 8
) (
  input  logic       clk,
  input  logic       rstN,
  output logic       refreshReq,
  input  logic       refreshGnt,
  output logic       refreshDone,
  input  logic       srEnter,
  input  logic       srExit,
  output logic       memCke,
  output logic       memCsN,
  output logic       memRasN,
  output logic       memCasN,
  output logic       memWeN,
  output logic       memA10,
  output logic [1:0] seqStatus,
  output logic       pendErr
);

  // nanosecond figures rounded up to whole clocks, never below two
  localparam int T_RP_RAW     = (T_RP_NS * CLK_MHZ + 999) / 1000;
  localparam int T_RC_RAW     = (T_RC_NS * CLK_MHZ + 999) / 1000;
  localparam int T_RP_CYC     = (T_RP_RAW < 2) ? 2 : T_RP_RAW;
  localparam int T_RC_CYC     = (T_RC_RAW < 2) ? 2 : T_RC_RAW;
  localparam int IV_RAW       = (REF_INTERVAL_NS * CLK_MHZ) / 1000;
  localparam int INTERVAL_CYC = (IV_RAW < 1) ? 1 : IV_RAW;
  localparam int JOB_LEN      = BURST_MODE ? BURST_LEN : 1;

  seqStrobe_t strobe;
  seqFlags_t  flags;

  refresh_seq_ctrl #(
    .RECOVER_BURST(BURST_MODE)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .refreshGnt (refreshGnt),
    .srEnter    (srEnter),
    .srExit     (srExit),
    .flags      (flags),
    .strobe     (strobe),
    .refreshReq (refreshReq),
    .refreshDone(refreshDone),
    .memCke     (memCke),
    .memCsN     (memCsN),
    .memRasN    (memRasN),
    .memCasN    (memCasN),
    .memWeN     (memWeN),
    .memA10     (memA10),
    .seqStatus  (seqStatus)
  );

  refresh_seq_dpath #(
    .T_RP_CYC    (T_RP_CYC),
    .T_RC_CYC    (T_RC_CYC),
    .INTERVAL_CYC(INTERVAL_CYC),
    .JOB_LEN     (JOB_LEN),
    .BURST_LEN   (BURST_LEN),
    .PEND_MAX    (PEND_MAX)
  ) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .flags  (flags),
    .pendErr(pendErr)
  );

endmodule

// File: rtl/refresh_seq_chk.sv
module refresh_seq_chk #(
  parameter int CLK_MHZ = 100,
  parameter int T_RC_NS = 60
) (
  input logic       clk,
  input logic       rstN,
  input logic       refreshReq,
  input logic       refreshDone,
  input logic       memCke,
  input logic       memCsN,
  input logic       memRasN,
  input logic       memCasN,
  input logic       memWeN,
  input logic       memA10,
  input logic [1:0] seqStatus,
  input logic       pendErr
);

  localparam int RC_RAW = (T_RC_NS * CLK_MHZ + 999) / 1000;
  localparam int RC_CYC = (RC_RAW < 2) ? 2 : RC_RAW;

  logic        isNop, isPre, isRef, ckeQ, ckeRise;
  int unsigned sinceRise;

  assign isNop   = memCsN || (memRasN && memCasN && memWeN);
  assign isPre   = !memCsN && !memRasN && memCasN && !memWeN;
  assign isRef   = !memCsN && !memRasN && !memCasN && memWeN;
  assign ckeRise = memCke && !ckeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ckeQ      <= 1'b1;
      sinceRise <= RC_CYC;
    end else begin
      ckeQ <= memCke;
      if (ckeRise)                  sinceRise <= 1;
      else if (sinceRise < RC_CYC)  sinceRise <= sinceRise + 1;
    end
  end

  p_pre_a10_r1: assert property (@(posedge clk) disable iff (!rstN)
    isPre |-> memA10);

  p_ref_cke_r3: assert property (@(posedge clk) disable iff (!rstN)
    (isRef && memCke) |-> $past(memCke));

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    refreshDone |=> !refreshDone);

  p_req_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    refreshReq |-> (seqStatus == 2'd0));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    pendErr |=> pendErr);

  p_sre_enc_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memCke) |-> isRef);

  p_self_nop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!memCke && $past(!memCke)) |-> isNop);

  p_exit_nop_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ckeRise || (sinceRise < RC_CYC)) |-> isNop);

  p_status_cke_r11: assert property (@(posedge clk) disable iff (!rstN)
    !memCke |-> (seqStatus == 2'd2));

endmodule

bind refresh_seq refresh_seq_chk #(
  .CLK_MHZ(CLK_MHZ),
  .T_RC_NS(T_RC_NS)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .refreshReq (refreshReq),
  .refreshDone(refreshDone),
  .memCke     (memCke),
  .memCsN     (memCsN),
  .memRasN    (memRasN),
  .memCasN    (memCasN),
  .memWeN     (memWeN),
  .memA10     (memA10),
  .seqStatus  (seqStatus),
  .pendErr    (pendErr)
);

// File: tb/tb_refresh_seq.sv
module tb_refresh_seq;

  localparam int RP = 3;   // 25 ns at 100 MHz rounds up to 3
  localparam int RC = 5;   // 45 ns at 100 MHz rounds up to 5
  localparam int BL = 3;

  localparam int EV_PRE  = 1;
  localparam int EV_REF  = 2;
  localparam int EV_SRE  = 3;
  localparam int EV_RISE = 4;
  localparam int EV_DONE = 5;
  localparam int EV_BAD  = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refreshGnt = 1'b0, srEnter = 1'b0, srExit = 1'b0;
  logic refreshReq, refreshDone, memCke, memCsN, memRasN, memCasN, memWeN, memA10, pendErr;
  logic [1:0] seqStatus;

  refresh_seq #(
    .CLK_MHZ(100), .T_RP_NS(25), .T_RC_NS(45), .REF_INTERVAL_NS(1000),
    .BURST_MODE(1'b1), .BURST_LEN(BL), .PEND_MAX(8)
  ) dut (
    .clk(clk), .rstN(rstN), .refreshReq(refreshReq), .refreshGnt(refreshGnt),
    .refreshDone(refreshDone), .srEnter(srEnter), .srExit(srExit),
    .memCke(memCke), .memCsN(memCsN), .memRasN(memRasN), .memCasN(memCasN),
    .memWeN(memWeN), .memA10(memA10), .seqStatus(seqStatus), .pendErr(pendErr)
  );

  always #5 clk = ~clk;

  typedef struct {
    int    kind;
    int    gap;    // 0: not checked
    int    status;
    string req;
  } evt_t;

  evt_t expQ[$];
  int   total = 0, bad = 0;
  int   cycle = 0, lastEv = 0;
  logic prevCke = 1'b1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expectEv(input int kind, input int gap, input int status, input string req);
    evt_t e;
    e.kind = kind; e.gap = gap; e.status = status; e.req = req;
    expQ.push_back(e);
  endtask

  // monitor: classify the bus every cycle and compare against the queue
  always @(negedge clk) begin
    if (rstN) begin
      int kind;
      cycle++;
      kind = 0;
      if (refreshDone) kind = EV_DONE;
      else if (memCke && !prevCke) kind = EV_RISE;
      else if (!memCsN && !(memRasN && memCasN && memWeN)) begin
        if (!memRasN && memCasN && !memWeN && memA10) kind = EV_PRE;
        else if (!memRasN && !memCasN && memWeN && memCke) kind = EV_REF;
        else if (!memRasN && !memCasN && memWeN && !memCke && prevCke) kind = EV_SRE;
        else kind = EV_BAD;
      end
      if (kind != 0) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R5", "unexpected bus event", kind, 0);
        end else begin
          evt_t e;
          e = expQ.pop_front();
          check(kind == e.kind, e.req, "event kind", kind, e.kind);
          if (e.gap > 0) check(cycle - lastEv == e.gap, e.req, "event spacing", cycle - lastEv, e.gap);
          check(int'(seqStatus) == e.status, "R11", "status at event", int'(seqStatus), e.status);
        end
        lastEv = cycle;
      end
      prevCke = memCke;
    end
  end

  task automatic waitDone(input string req);
    int n;
    n = 0;
    while (!refreshDone && n < 300) begin
      @(negedge clk);
      n++;
    end
    check(refreshDone == 1'b1, req, "done pulse seen", int'(refreshDone), 1);
  endtask

  // one refresh job: precharge-all, BL refreshes, done
  task automatic serveJob(input string req);
    expectEv(EV_PRE, 0, 1, "R1");
    expectEv(EV_REF, RP, 1, "R2");
    for (int i = 1; i < BL; i++) expectEv(EV_REF, RC, 1, "R3");
    expectEv(EV_DONE, RC, 1, "R4");
    @(negedge clk);
    refreshGnt = 1'b1;
    @(negedge clk);
    waitDone(req);
    refreshGnt = 1'b0;
    @(posedge clk);
    check(expQ.size() == 0, req, "job events left", expQ.size(), 0);
  endtask

  task automatic finishRun();
    check(expQ.size() == 0, "R4", "events left at end", expQ.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int served;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(memCke == 1'b1, "R12", "cke in reset", int'(memCke), 1);
    check({memCsN, memRasN, memCasN, memWeN} == 4'b0111, "R12", "nop in reset",
          int'({memCsN, memRasN, memCasN, memWeN}), 7);
    check(seqStatus == 2'd0, "R12", "status in reset", int'(seqStatus), 0);
    check(!refreshReq && !refreshDone && !pendErr, "R12", "flags in reset",
          int'({refreshReq, refreshDone, pendErr}), 0);
    rstN = 1'b1;

    // R5 first interval after 100 clocks
    repeat (99) @(posedge clk);
    @(negedge clk);
    check(refreshReq == 1'b0, "R5", "req before interval", int'(refreshReq), 0);
    @(negedge clk);
    check(refreshReq == 1'b1, "R5", "req at interval", int'(refreshReq), 1);
    repeat (5) @(negedge clk);
    check(seqStatus == 2'd0, "R5", "idle without grant", int'(seqStatus), 0);

    serveJob("R4");
    @(negedge clk);
    check(refreshReq == 1'b0, "R5", "req after job", int'(refreshReq), 0);

    // R9 exit request while idle does nothing
    srExit = 1'b1;
    repeat (4) @(negedge clk);
    check(seqStatus == 2'd0, "R9", "status with stray exit", int'(seqStatus), 0);
    check(memCke == 1'b1, "R9", "cke with stray exit", int'(memCke), 1);

    // self-refresh with exit held high from the start (R8, R9, R10)
    srEnter = 1'b1;
    @(negedge clk);
    check(refreshReq == 1'b1, "R5", "req on srEnter", int'(refreshReq), 1);
    expectEv(EV_PRE, 0, 1, "R8");
    expectEv(EV_SRE, RP, 2, "R8");
    expectEv(EV_RISE, 3, 3, "R9");
    expectEv(EV_REF, RC, 1, "R10");
    for (int i = 1; i < BL; i++) expectEv(EV_REF, RC, 1, "R10");
    expectEv(EV_DONE, RC, 1, "R10");
    refreshGnt = 1'b1;
    begin
      int n;
      n = 0;
      while (seqStatus != 2'd2 && n < 50) begin
        @(negedge clk);
        n++;
      end
      check(seqStatus == 2'd2, "R11", "reached self-refresh", int'(seqStatus), 2);
      check(memCke == 1'b0, "R8", "cke low on entry", int'(memCke), 0);
    end
    srEnter = 1'b0;
    waitDone("R10");
    refreshGnt = 1'b0;
    srExit = 1'b0;
    @(posedge clk);
    check(expQ.size() == 0, "R10", "self-refresh events left", expQ.size(), 0);

    // R6 postponed intervals
    repeat (350) @(posedge clk);
    @(negedge clk);
    check(refreshReq == 1'b1, "R6", "req while postponed", int'(refreshReq), 1);
    served = 0;
    while (refreshReq && served < 12) begin
      serveJob("R6");
      served++;
      @(negedge clk);
    end
    check(served >= 3, "R6", "jobs served", served, 3);
    check(pendErr == 1'b0, "R7", "no overflow yet", int'(pendErr), 0);

    // R7 overflow after more than eight postponed intervals
    repeat (1000) @(posedge clk);
    @(negedge clk);
    check(pendErr == 1'b1, "R7", "overflow flag", int'(pendErr), 1);
    serveJob("R7");
    @(negedge clk);
    check(pendErr == 1'b1, "R7", "flag sticky", int'(pendErr), 1);

    finishRun();
  end

endmodule